// File: doc/BRIEF.md
# Dual-Push Register Stack File

This block holds the eight-word operand stack of a zero-address processor. Arithmetic operands are always taken from the top of the stack. A wrapping top-of-stack pointer tracks the top, so a push or pop moves only the pointer and writes at most two slots. The block never moves words from slot to slot.

Two write ports let a pair of instructions change the stack in one clock. Supported pairs are:
- two literal loads pushed together;
- a word assembled from a left half-word literal and a right half-word literal;
- a push whose new top is immediately overwritten by the second instruction.

Three read ports are combinational views of the registered slots: the top word, the word below it, and a word at any offset below the top. A depth counter saturates at both ends and raises one-cycle overflow and underflow flags.

The operation interface carries no stream data. It is a plain command: one opcode and two data words, sampled on every rising clock edge. There is no handshake and no back-pressure, so the block accepts one operation per cycle unconditionally.

Top module: `pair_stack_regfile`

## Requirements
- R1: While `rst_n` is low, every slot is cleared, the pointer and `depth` are 0, and `ovf` and `unf` are 0.
- R2: Opcode 1 (single push) places `data_a` on top one cycle later, the previous top becomes `next_word`, and `depth` rises by 1.
- R3: Opcode 2 (pop) makes the previous `next_word` the new top one cycle later, and `depth` falls by 1.
- R4: Opcode 3 (double push) pushes `data_a` and then `data_b` in one cycle: `data_b` becomes top, `data_a` becomes `next_word`, and `depth` rises by 2.
- R5: Opcode 4 (half-word merge) pushes one word. Its upper half is the lower half of `data_a` and its lower half is the lower half of `data_b`.
- R6: Opcode 5 (push then overwrite) makes both writes target the same new slot, and the second write, `data_b`, wins. `depth` rises by 1.
- R7: Opcode 6 (replace) overwrites the current top with `data_a` and leaves `depth` and `next_word` unchanged.
- R8: A push-type opcode whose result would exceed 8 words still writes and advances the pointer modulo 8. `depth` stays at 8, and `ovf` is 1 for the following cycle only.
- R9: A pop at depth 0 leaves `depth` at 0 and sets `unf` for the following cycle only.
- R10: Opcode 0 and the unused opcode 7 change no slot, pointer or depth.
- R11: `peek_word` returns the slot `peek_off` positions below the top. All three read ports show the pre-write contents during the cycle in which a write to the same slot is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation code, sampled every cycle |
| data_a | input | WIDTH | First instruction's literal or data |
| data_b | input | WIDTH | Second instruction's literal or data |
| peek_off | input | log2(DEPTH) | Offset below the top for `peek_word` |
| top_word | output | WIDTH | Current top of stack |
| next_word | output | WIDTH | Word directly below the top |
| peek_word | output | WIDTH | Word `peek_off` below the top |
| depth | output | log2(DEPTH)+1 | Number of valid words, 0 to DEPTH |
| ovf | output | 1 | One-cycle overflow pulse |
| unf | output | 1 | One-cycle underflow pulse |

## Verification
The assertions check the following relations on every cycle:
- each opcode against the top and next words it must produce one cycle later, including the second-write-wins case and the half-word merge;
- the saturation limits of `depth` and the conditions under which the overflow and underflow pulses may appear.

Some behaviours only the bench's scenarios can show:
- that the pointer wraps so an overwritten oldest slot reappears after a long push run;
- that reads return pre-write values before the edge;
- that a reset in mid-run clears all slots;
- that a full run of pops walks back through earlier pushes in order.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_PUSH      = 3'd1,
    OP_POP       = 3'd2,
    OP_PUSH2     = 3'd3,
    OP_PUSH_HL   = 3'd4,
    OP_PUSH_REPL = 3'd5,
    OP_REPL      = 3'd6,
    OP_RSVD      = 3'd7
  } stk_op_e;

  function automatic logic is_push(input stk_op_e o);
    return (o == OP_PUSH) || (o == OP_PUSH2) || (o == OP_PUSH_HL) ||
           (o == OP_PUSH_REPL);
  endfunction

endpackage

// File: rtl/stk_word_merge.sv
module stk_word_merge #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] hi_src,
  input  logic [WIDTH-1:0] lo_src,
  output logic [WIDTH-1:0] merged
);
  localparam int HALF = WIDTH / 2;

  // Left literal lands in the upper half, right literal in the lower half.
  assign merged = {hi_src[HALF-1:0], lo_src[HALF-1:0]};

endmodule

// File: rtl/stk_ptr_ctrl.sv
module stk_ptr_ctrl
  import stk_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_op_e          op,
  input  logic [WIDTH-1:0] data_a,
  input  logic [WIDTH-1:0] data_b,
  input  logic [WIDTH-1:0] merged,
  output logic [PW-1:0]    tos,
  output logic [PW:0]      depth,
  output logic             ovf,
  output logic             unf,
  output logic             wa_en,
  output logic [PW-1:0]    wa_addr,
  output logic [WIDTH-1:0] wa_data,
  output logic             wb_en,
  output logic [PW-1:0]    wb_addr,
  output logic [WIDTH-1:0] wb_data
);
  localparam logic [PW+1:0] FULL = (PW+2)'(DEPTH);
  localparam logic [PW-1:0] ONE  = PW'(1);
  localparam logic [PW-1:0] TWO  = PW'(2);

  logic [1:0]    grow;
  logic          shrink;
  logic [PW+1:0] sum;
  logic [PW-1:0] tos_nxt;
  logic [PW:0]   depth_nxt;
  logic          ovf_nxt;
  logic          unf_nxt;

  // Port A is the first instruction of a pair, port B the second.
  always_comb begin
    wa_en   = 1'b0;
    wa_addr = tos + ONE;
    wa_data = data_a;
    wb_en   = 1'b0;
    wb_addr = tos + TWO;
    wb_data = data_b;
    grow    = 2'd0;
    shrink  = 1'b0;
    unique case (op)
      OP_PUSH: begin
        wa_en = 1'b1;
        grow  = 2'd1;
      end
      OP_PUSH2: begin
        wa_en = 1'b1;
        wb_en = 1'b1;
        grow  = 2'd2;
      end
      OP_PUSH_HL: begin
        wa_en   = 1'b1;
        wa_data = merged;
        grow    = 2'd1;
      end
      OP_PUSH_REPL: begin
        wa_en   = 1'b1;
        wb_en   = 1'b1;
        wb_addr = tos + ONE;
        grow    = 2'd1;
      end
      OP_REPL: begin
        wa_en   = 1'b1;
        wa_addr = tos;
      end
      OP_POP: shrink = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    sum       = {1'b0, depth} + (PW+2)'(grow);
    ovf_nxt   = 1'b0;
    unf_nxt   = 1'b0;
    depth_nxt = depth;
    tos_nxt   = shrink ? (tos - ONE) : (tos + PW'(grow));
    if (shrink) begin
      if (depth == '0) unf_nxt = 1'b1;
      else             depth_nxt = depth - 1'b1;
    end else if (sum > FULL) begin
      ovf_nxt   = 1'b1;
      depth_nxt = FULL[PW:0];
    end else begin
      depth_nxt = sum[PW:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tos   <= '0;
      depth <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      tos   <= tos_nxt;
      depth <= depth_nxt;
      ovf   <= ovf_nxt;
      unf   <= unf_nxt;
    end
  end

endmodule

// File: rtl/stk_slot_array.sv
module stk_slot_array #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wa_en,
  input  logic [PW-1:0]    wa_addr,
  input  logic [WIDTH-1:0] wa_data,
  input  logic             wb_en,
  input  logic [PW-1:0]    wb_addr,
  input  logic [WIDTH-1:0] wb_data,
  input  logic [PW-1:0]    rd_top_addr,
  input  logic [PW-1:0]    rd_next_addr,
  input  logic [PW-1:0]    rd_peek_addr,
  output logic [WIDTH-1:0] rd_top,
  output logic [WIDTH-1:0] rd_next,
  output logic [WIDTH-1:0] rd_peek
);
  logic [WIDTH-1:0] slots [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [WIDTH-1:0] slot_q;
    logic             hit_a;
    logic             hit_b;

    assign hit_a = wa_en && (wa_addr == PW'(g));
    assign hit_b = wb_en && (wb_addr == PW'(g));

    // The second instruction's port takes priority on a shared slot.
    always_ff @(posedge clk) begin
      if (!rst_n)     slot_q <= '0;
      else if (hit_b) slot_q <= wb_data;
      else if (hit_a) slot_q <= wa_data;
    end

    assign slots[g] = slot_q;
  end

  // Reads see registered contents only: a pending write shows after the edge.
  assign rd_top  = slots[rd_top_addr];
  assign rd_next = slots[rd_next_addr];
  assign rd_peek = slots[rd_peek_addr];

endmodule

// File: rtl/pair_stack_regfile.sv
module pair_stack_regfile #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] data_a,
  input  logic [WIDTH-1:0] data_b,
  input  logic [PW-1:0]    peek_off,
  output logic [WIDTH-1:0] top_word,
  output logic [WIDTH-1:0] next_word,
  output logic [WIDTH-1:0] peek_word,
  output logic [PW:0]      depth,
  output logic             ovf,
  output logic             unf
);
  logic [WIDTH-1:0] merged;
  logic [PW-1:0]    tos;
  logic             wa_en;
  logic [PW-1:0]    wa_addr;
  logic [WIDTH-1:0] wa_data;
  logic             wb_en;
  logic [PW-1:0]    wb_addr;
  logic [WIDTH-1:0] wb_data;

  stk_word_merge #(.WIDTH(WIDTH)) u_merge (
    .hi_src (data_a),
    .lo_src (data_b),
    .merged (merged)
  );

  stk_ptr_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (stk_pkg::stk_op_e'(op)),
    .data_a  (data_a),
    .data_b  (data_b),
    .merged  (merged),
    .tos     (tos),
    .depth   (depth),
    .ovf     (ovf),
    .unf     (unf),
    .wa_en   (wa_en),
    .wa_addr (wa_addr),
    .wa_data (wa_data),
    .wb_en   (wb_en),
    .wb_addr (wb_addr),
    .wb_data (wb_data)
  );

  stk_slot_array #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_slots (
    .clk          (clk),
    .rst_n        (rst_n),
    .wa_en        (wa_en),
    .wa_addr      (wa_addr),
    .wa_data      (wa_data),
    .wb_en        (wb_en),
    .wb_addr      (wb_addr),
    .wb_data      (wb_data),
    .rd_top_addr  (tos),
    .rd_next_addr (tos - PW'(1)),
    .rd_peek_addr (tos - peek_off),
    .rd_top       (top_word),
    .rd_next      (next_word),
    .rd_peek      (peek_word)
  );

endmodule

// File: rtl/stk_checker.sv
module stk_checker
  import stk_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op,
  input logic [WIDTH-1:0] data_a,
  input logic [WIDTH-1:0] data_b,
  input logic [WIDTH-1:0] top_word,
  input logic [WIDTH-1:0] next_word,
  input logic [PW:0]      depth,
  input logic             ovf,
  input logic             unf
);
  localparam int HALF = WIDTH / 2;
  localparam logic [PW:0] FULL = (PW+1)'(DEPTH);

  logic push_op;
  assign push_op = is_push(stk_op_e'(op));

  p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH) |=> (top_word == $past(data_a)) && (next_word == $past(top_word)));

  p_pop_expose_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP) |=> (top_word == $past(next_word)));

  p_double_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH2) |=> (top_word == $past(data_b)) && (next_word == $past(data_a)));

  p_half_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH_HL) |=>
      (top_word == {$past(data_a[HALF-1:0]), $past(data_b[HALF-1:0])}));

  p_second_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH_REPL) |=> (top_word == $past(data_b)) && (next_word == $past(top_word)));

  p_replace_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_REPL) |=> (top_word == $past(data_a)) && $stable(depth) && $stable(next_word));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= FULL);

  p_ovf_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_op && depth == FULL) |=> ovf && (depth == FULL));

  p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(push_op));

  p_unf_when_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && depth == '0) |=> unf && (depth == '0));

  p_unf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> $past(op == OP_POP));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP || op == OP_RSVD) |=>
      $stable(top_word) && $stable(next_word) && $stable(depth));

endmodule

bind pair_stack_regfile stk_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op        (op),
  .data_a    (data_a),
  .data_b    (data_b),
  .top_word  (top_word),
  .next_word (next_word),
  .depth     (depth),
  .ovf       (ovf),
  .unf       (unf)
);

// File: tb/pair_stack_regfile_tb.sv
`timescale 1ns/1ps
module pair_stack_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op;
  logic [15:0] data_a;
  logic [15:0] data_b;
  logic [2:0]  peek_off;
  logic [15:0] top_word;
  logic [15:0] next_word;
  logic [15:0] peek_word;
  logic [3:0]  depth;
  logic        ovf;
  logic        unf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pair_stack_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .op(op), .data_a(data_a), .data_b(data_b),
    .peek_off(peek_off), .top_word(top_word), .next_word(next_word),
    .peek_word(peek_word), .depth(depth), .ovf(ovf), .unf(unf)
  );

  // {op, data_a, data_b, expected top, expected next, expected depth}
  localparam int NV = 10;
  localparam logic [70:0] VEC [NV] = '{
    {3'd1, 16'h1111, 16'h0000, 16'h1111, 16'h0000, 4'd1},
    {3'd1, 16'h2222, 16'h0000, 16'h2222, 16'h1111, 4'd2},
    {3'd3, 16'h3333, 16'h4444, 16'h4444, 16'h3333, 4'd4},
    {3'd2, 16'h0000, 16'h0000, 16'h3333, 16'h2222, 4'd3},
    {3'd4, 16'h12AB, 16'h34CD, 16'hABCD, 16'h3333, 4'd4},
    {3'd5, 16'h5555, 16'h6666, 16'h6666, 16'hABCD, 4'd5},
    {3'd6, 16'h7777, 16'h0000, 16'h7777, 16'hABCD, 4'd5},
    {3'd0, 16'hFFFF, 16'hFFFF, 16'h7777, 16'hABCD, 4'd5},
    {3'd7, 16'hEEEE, 16'hEEEE, 16'h7777, 16'hABCD, 4'd5},
    {3'd2, 16'h0000, 16'h0000, 16'hABCD, 16'h3333, 4'd4}
  };

  function automatic string vec_tag(input logic [2:0] o);
    case (o)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    op = o; data_a = a; data_b = b;
    @(posedge clk);
    #1;
    op = 3'd0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op = 3'd0; data_a = '0; data_b = '0; peek_off = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 depth", 32'(depth), 0);
    check("R1 top", 32'(top_word), 0);
    check("R1 next", 32'(next_word), 0);
    check("R1 flags", {30'd0, ovf, unf}, 0);
    @(negedge clk); rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [70:0] v;
      v = VEC[i];
      step(v[70:68], v[67:52], v[51:36]);
      check({vec_tag(v[70:68]), " top"},   32'(top_word),  32'(v[35:20]));
      check({vec_tag(v[70:68]), " next"},  32'(next_word), 32'(v[19:4]));
      check({vec_tag(v[70:68]), " depth"}, 32'(depth),     32'(v[3:0]));
    end

    // R8: fill to 8 words, then overflow with a double push
    for (int k = 1; k <= 4; k++) step(3'd1, 16'hA000 + 16'(k), 16'h0);
    check("R8 depth at full", 32'(depth), 8);
    check("R8 no ovf on reaching full", 32'(ovf), 0);
    step(3'd3, 16'hB001, 16'hB002);
    check("R8 ovf pulse", 32'(ovf), 1);
    check("R8 depth saturates", 32'(depth), 8);
    check("R8 wrapped top", 32'(top_word), 32'h0000B002);
    check("R8 wrapped next", 32'(next_word), 32'h0000B001);
    step(3'd0, 16'h0, 16'h0);
    check("R8 ovf one cycle", 32'(ovf), 0);

    // R9: drain and underflow
    step(3'd2, 16'h0, 16'h0);
    check("R3 pop exposes", 32'(top_word), 32'h0000B001);
    for (int k = 0; k < 7; k++) step(3'd2, 16'h0, 16'h0);
    check("R9 empty depth", 32'(depth), 0);
    check("R9 no unf on reaching empty", 32'(unf), 0);
    step(3'd2, 16'h0, 16'h0);
    check("R9 unf pulse", 32'(unf), 1);
    check("R9 depth holds 0", 32'(depth), 0);
    step(3'd0, 16'h0, 16'h0);
    check("R9 unf one cycle", 32'(unf), 0);

    // R1: mid-run reset clears slots
    step(3'd3, 16'hC001, 16'hC002);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 mid reset top", 32'(top_word), 0);
    check("R1 mid reset next", 32'(next_word), 0);
    check("R1 mid reset depth", 32'(depth), 0);
    @(negedge clk); rst_n = 1'b1;

    // R11: reads return old contents before the edge, peek offsets
    step(3'd1, 16'h1234, 16'h0);
    @(negedge clk);
    op = 3'd1; data_a = 16'h9999; peek_off = 3'd0;
    #1;
    check("R11 top before edge", 32'(top_word), 32'h00001234);
    check("R11 peek before edge", 32'(peek_word), 32'h00001234);
    @(posedge clk); #1;
    op = 3'd0;
    check("R11 top after edge", 32'(top_word), 32'h00009999);
    peek_off = 3'd1;
    #1;
    check("R11 peek offset 1", 32'(peek_word), 32'h00001234);
    peek_off = 3'd2;
    #1;
    check("R11 peek offset 2", 32'(peek_word), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule